// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block sits between a synchronous host and an asynchronous byte-wide read-only memory of 32K locations. When the host raises a read request, the block drives the address, pulls the active-low chip select low, and lowers the active-low output-gate strobe a computed number of cycles later. It waits until the memory's slowest access path has settled, then latches the byte. In the same clock edge it releases both strobes and gives the host a one-cycle ready pulse.

Every wait is a count of clock cycles. The counts are worked out at elaboration from a clock-period parameter and from the timing set that a speed-grade parameter selects. There are five grades. For each grade, the pairs below give address/select access, gate access and float time in ns: grade 0 is 90/40/30, grade 1 is 100/45/30, grade 2 is 120/55/35, grade 3 is 150/65/50 and grade 4 is 200/75/55. The select access equals the address access in every grade.

After each access the block leaves a turnaround gap. This gives the memory's output drivers time to float before another access is started on the shared data bus.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, the select and gate strobes are high (inactive), ready is low and the read-data output is zero.
- R2: A request seen while the block is idle and past its turnaround gap is accepted at that clock edge. The select strobe falls and the address output takes the host address in that same cycle. The address output stays constant for as long as the select strobe is low.
- R3: The gate strobe falls L = floor((tCE − tOE) / T) cycles after the select strobe falls, where T is the clock period. It is never low while the select strobe is high. For grade 0 at T = 10 ns, L = 5.
- R4: The byte is captured C = max(ceil(tACC / T), L + ceil(tOE / T)) + 1 cycles after the select strobe falls, with the strobes still low at that edge. The extra cycle is a synchronizer margin. At that edge both strobes rise and ready goes high, and the read-data output carries the byte present at that edge. For grade 0 at T = 10 ns, C = 10.
- R5: Ready is high for exactly one cycle per access. The read-data output keeps its value until the next ready pulse.
- R6: With F = ceil(tOFF / T), the select strobe cannot fall again until F + 1 cycles after the strobes rose. When a request is already waiting, the next access starts exactly F + 1 cycles after the strobes rose. For grade 0 at T = 10 ns, F = 3.
- R7: Dropping the request while an access is in progress does not shorten or cancel that access. Every accepted request produces exactly one ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host read request (level) |
| host_addr | input | 15 | Byte address from the host |
| rom_addr | output | 15 | Address driven to the memory |
| rom_ce_n | output | 1 | Active-low chip select |
| rom_oe_n | output | 1 | Active-low output gate |
| rom_data | input | 8 | Data bus from the memory |
| rd_data | output | 8 | Captured byte |
| rd_ready | output | 1 | One-cycle completion pulse |

## Verification
Two events can land on the same clock edge. The first is capture: the byte is latched on the same edge that raises both strobes and fires ready. The bench's memory model only returns the true byte once both the select time and the gate time have passed since their strobes fell, and it returns the inverted byte otherwise. A capture that is one cycle early is therefore caught by a wrong byte, and one that is late is caught by the latency count. The second is the end of the turnaround gap. The bench holds the request high across a burst, so the next request is already waiting on the very cycle the gap expires. It then checks that the select strobe falls again exactly F + 1 cycles after it rose.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

    typedef struct packed {
        int unsigned t_acc;
        int unsigned t_ce;
        int unsigned t_oe;
        int unsigned t_off;
    } grade_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } state_e;

    function automatic grade_t grade_timing(input int unsigned g);
        grade_t r;
        case (g)
            1:       r = '{t_acc: 100, t_ce: 100, t_oe: 45, t_off: 30};
            2:       r = '{t_acc: 120, t_ce: 120, t_oe: 55, t_off: 35};
            3:       r = '{t_acc: 150, t_ce: 150, t_oe: 65, t_off: 50};
            4:       r = '{t_acc: 200, t_ce: 200, t_oe: 75, t_off: 55};
            default: r = '{t_acc: 90,  t_ce: 90,  t_oe: 40, t_off: 30};
        endcase
        return r;
    endfunction

    function automatic int unsigned ceil_div(input int unsigned a, input int unsigned b);
        return (a + b - 1) / b;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned oe_lag(input int unsigned g, input int unsigned t);
        grade_t r = grade_timing(g);
        return (r.t_ce - r.t_oe) / t;
    endfunction

    function automatic int unsigned capture_cycles(input int unsigned g, input int unsigned t);
        grade_t r = grade_timing(g);
        int unsigned n_acc = ceil_div(umax(r.t_acc, r.t_ce), t);
        int unsigned n_oe  = oe_lag(g, t) + ceil_div(r.t_oe, t);
        return umax(n_acc, n_oe) + 1;
    endfunction

    function automatic int unsigned float_cycles(input int unsigned g, input int unsigned t);
        grade_t r = grade_timing(g);
        return ceil_div(r.t_off, t);
    endfunction

endpackage

// File: rtl/rom_rd_gap.sv
module rom_rd_gap #(
    parameter int unsigned FLOAT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int GW = $clog2(FLOAT_CYC + 2);

    logic [GW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= GW'(FLOAT_CYC);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign busy = (left_q != '0);
endmodule

// File: rtl/rom_rd_capture.sv
module rom_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] data_q,
    output logic              ready_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= take;
            if (take) data_q <= bus_in;
        end
    end
endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
    import rom_rd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned GRADE         = 0,
    parameter int          ADDR_W        = 15,
    parameter int          DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] host_addr,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_ready
);
    localparam int unsigned LAG  = oe_lag(GRADE, CLK_PERIOD_NS);
    localparam int unsigned CAP  = capture_cycles(GRADE, CLK_PERIOD_NS);
    localparam int unsigned FLT  = float_cycles(GRADE, CLK_PERIOD_NS);
    localparam int          CW   = $clog2(CAP + 1);
    localparam int unsigned LAGM = (LAG == 0) ? 0 : LAG - 1;

    state_e            state_q;
    logic [CW-1:0]     cnt_q;
    logic              gap_busy;
    logic              done;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && req && !gap_busy;
    assign done   = (state_q == ST_ACCESS) && (cnt_q == CW'(CAP - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            rom_addr <= '0;
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        rom_addr <= host_addr;
                        rom_ce_n <= 1'b0;
                        rom_oe_n <= (LAG != 0) ? 1'b1 : 1'b0;
                        cnt_q    <= '0;
                        state_q  <= ST_ACCESS;
                    end
                end
                default: begin
                    cnt_q <= cnt_q + 1'b1;
                    if ((LAG != 0) && (cnt_q == CW'(LAGM))) rom_oe_n <= 1'b0;
                    if (done) begin
                        rom_ce_n <= 1'b1;
                        rom_oe_n <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    rom_rd_gap #(.FLOAT_CYC(FLT)) u_gap (
        .clk   (clk),
        .rst   (rst),
        .start (done),
        .busy  (gap_busy)
    );

    rom_rd_capture #(.DATA_W(DATA_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .take    (done),
        .bus_in  (rom_data),
        .data_q  (rd_data),
        .ready_q (rd_ready)
    );
endmodule

// File: rtl/rom_rd_ctrl_chk.sv
module rom_rd_ctrl_chk
    import rom_rd_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned GRADE         = 0,
    parameter int          ADDR_W        = 15,
    parameter int          DATA_W        = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_ready
);
    localparam int unsigned GAP = float_cycles(GRADE, CLK_PERIOD_NS) + 1;
    localparam int          HW  = $clog2(GAP + 2);

    logic [HW-1:0] high_cnt;

    always_ff @(posedge clk) begin
        if (rst) high_cnt <= HW'(GAP);
        else if (!rom_ce_n) high_cnt <= '0;
        else if (high_cnt < HW'(GAP)) high_cnt <= high_cnt + 1'b1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (rom_ce_n && rom_oe_n && !rd_ready && rd_data == '0));

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!rom_ce_n && $past(!rom_ce_n)) |-> $stable(rom_addr));

    a_r3_oe_inside_ce: assert property (@(posedge clk) disable iff (rst)
        !rom_oe_n |-> !rom_ce_n);

    a_r4_ready_closes: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> (rom_ce_n && rom_oe_n && $past(!rom_oe_n)));

    a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_ready |=> !rd_ready);

    a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_ready |-> $stable(rd_data));

    a_r6_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(rom_ce_n) |-> (high_cnt >= HW'(GAP)));
endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .GRADE         (GRADE),
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rom_addr (rom_addr),
    .rom_ce_n (rom_ce_n),
    .rom_oe_n (rom_oe_n),
    .rd_data  (rd_data),
    .rd_ready (rd_ready)
);

// File: tb/rom_rd_ctrl_test.sv
module rom_rd_ctrl_test;
    localparam int CLK_NS = 10;
    // grade 0 numbers from the requirements
    localparam int T_ACC = 90, T_OE = 40, T_OFF = 30;
    localparam int N_ACC = (T_ACC + CLK_NS - 1) / CLK_NS;
    localparam int N_OE  = (T_OE + CLK_NS - 1) / CLK_NS;
    localparam int L_EXP = (T_ACC - T_OE) / CLK_NS;
    localparam int C_EXP = ((N_ACC > L_EXP + N_OE) ? N_ACC : L_EXP + N_OE) + 1;
    localparam int F_EXP = (T_OFF + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [14:0] host_addr = '0;
    logic [14:0] rom_addr;
    logic        rom_ce_n, rom_oe_n;
    logic [7:0]  rom_data = '0;
    logic [7:0]  rd_data;
    logic        rd_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit b2b = 0;
    int accepted = 0;
    int readies = 0;
    logic [7:0] exp_q[$];

    always #(CLK_NS/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rom_rd_ctrl uut (
        .clk(clk), .rst(rst), .req(req), .host_addr(host_addr),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_data(rom_data), .rd_data(rd_data), .rd_ready(rd_ready)
    );

    function automatic logic [7:0] rom_val(input logic [14:0] a);
        return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
    endfunction

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    // memory model: true byte only once both access windows have passed
    int ce_cnt = 0, oe_cnt = 0;
    always @(negedge clk) begin
        ce_cnt = rom_ce_n ? 0 : ce_cnt + 1;
        oe_cnt = rom_oe_n ? 0 : oe_cnt + 1;
        rom_data = (ce_cnt >= N_ACC && oe_cnt >= N_OE) ? rom_val(rom_addr) : ~rom_val(rom_addr);
    end

    // monitor / scoreboard
    logic prev_ce = 1'b1, prev_oe = 1'b1;
    int ce_fall = 0, ce_rise = -100;
    bit have_prev = 0;
    logic [14:0] addr_at_fall = '0;
    logic [7:0]  last_data = '0;
    bit addr_bad = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_ce && !rom_ce_n) begin
                ce_fall = cyc;
                addr_at_fall = rom_addr;
                addr_bad = 0;
                accepted++;
                check(rd_data == last_data, "R5 data held between accesses", rd_data, last_data);
                if (have_prev) begin
                    if (b2b) check(cyc - ce_rise == F_EXP + 1, "R6 exact gap", cyc - ce_rise, F_EXP + 1);
                    else     check(cyc - ce_rise >= F_EXP + 1, "R6 minimum gap", cyc - ce_rise, F_EXP + 1);
                end
            end
            if (!rom_ce_n && rom_addr != addr_at_fall) addr_bad = 1;
            if (prev_oe && !rom_oe_n)
                check(cyc - ce_fall == L_EXP, "R3 gate lag", cyc - ce_fall, L_EXP);
            if (!rom_oe_n && rom_ce_n)
                check(0, "R3 gate low with select high", 1, 0);
            if (rd_ready) begin
                readies++;
                ce_rise = cyc;
                have_prev = 1;
                check(cyc - ce_fall == C_EXP, "R4 capture latency", cyc - ce_fall, C_EXP);
                check(rom_ce_n && rom_oe_n, "R4 strobes released", {rom_ce_n, rom_oe_n}, 3);
                check(!addr_bad, "R2 address stable", addr_bad, 0);
                if (exp_q.size() == 0) check(0, "R7 unexpected ready", 1, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(rd_data == e, "R4 captured byte", rd_data, e);
                end
                last_data = rd_data;
            end
            if (prev_ce == 1'b0 && rd_ready == 1'b0 && rom_ce_n && readies == 0)
                check(0, "R4 strobes rose without ready", 0, 1);
            prev_ce = rom_ce_n;
            prev_oe = rom_oe_n;
        end
    end

    // one-cycle ready check
    logic prev_rdy = 1'b0;
    always @(negedge clk) begin
        if (!rst && prev_rdy) check(!rd_ready, "R5 ready one cycle", rd_ready, 0);
        prev_rdy = rd_ready;
    end

    task automatic do_read(input logic [14:0] a);
        @(negedge clk);
        host_addr = a;
        req = 1'b1;
        exp_q.push_back(rom_val(a));
        do @(negedge clk); while (rom_ce_n);
        check(rom_addr == a, "R2 address driven with select", rom_addr, a);
        req = 1'b0;   // R7: dropping the request does not cancel the access
        do @(negedge clk); while (!rd_ready);
    endtask

    task automatic do_burst(input logic [14:0] base, input int n);
        @(negedge clk);
        b2b = 1;
        host_addr = base;
        req = 1'b1;
        exp_q.push_back(rom_val(base));
        for (int i = 1; i <= n; i++) begin
            do @(negedge clk); while (!rd_ready);
            if (i < n) begin
                host_addr = base + 15'(i * 97);
                exp_q.push_back(rom_val(host_addr));
            end else req = 1'b0;
        end
        @(negedge clk);
        b2b = 0;
    endtask

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rom_ce_n && rom_oe_n, "R1 strobes high in reset", {rom_ce_n, rom_oe_n}, 3);
        check(!rd_ready, "R1 ready low in reset", rd_ready, 0);
        check(rd_data == 8'h00, "R1 data zero in reset", rd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        check(rom_ce_n && rom_oe_n && !rd_ready, "R1 idle after reset", {rom_ce_n, rom_oe_n, rd_ready}, 6);
        do_read(15'h0000);
        do_read(15'h7FFF);
        do_read(15'h1234);
        repeat (7) @(negedge clk);
        do_read(15'h5555);
        do_read(15'h2AAA);
        do_burst(15'h0100, 4);
        repeat (F_EXP + 3) @(negedge clk);
        check(accepted == readies, "R7 one ready per access", readies, accepted);
        check(exp_q.size() == 0, "R7 all requests completed", exp_q.size(), 0);
        check(rom_ce_n, "R7 no access without request", rom_ce_n, 1);
        finish_sim();
    end
endmodule